// File: doc/BRIEF.md
# Vector floating-point compare unit

This unit compares two 128-bit vectors lane by lane as IEEE-754 binary floating-point numbers and returns a lane mask. A precision select splits the vector into four 32-bit single-precision lanes or two 64-bit double-precision lanes. A 5-bit condition code picks the relation to test. Bit 0 of the code chooses a quiet or a signaling compare. Bits [4:1] choose the set of outcomes (less, equal, greater, unordered) that count as true. Each result lane is all ones when its outcome is in that set and all zeros when it is not.

The unit also reports an invalid-operation flag and marks condition codes that have no meaning. Every lane is evaluated from the sampled sources before the result register loads, so a source vector may safely be the vector the result overwrites. The result, the flag and the illegal-code indication are registered. They load on a cycle where the operation enable is high and hold their value otherwise.

Top module: `vfcmp_unit`

## Requirements
- R1: With `dbl_sel`=0 the vectors hold four 32-bit lanes (lane i at bits [32i+31:32i]). With `dbl_sel`=1 they hold two 64-bit lanes (lane i at bits [64i+63:64i]). Every result lane is either all ones or all zeros.
- R2: `cond[0]`=0 selects the quiet compare and `cond[0]`=1 selects the signaling compare. Bit 0 does not change the relation tested.
- R3: `cond[4:1]` selects the true outcomes as follows. 0 gives none. 1 gives less. 2 gives equal. 3 gives less or equal. 4 gives unordered. 5 gives unordered or less. 6 gives unordered or equal. 7 gives unordered, less or equal. 8 gives less or greater. 10 gives less, equal or greater (ordered). 12 gives unordered, less or greater.
- R4: Codes 0x12, 0x13, 0x16, 0x17 and 0x1A to 0x1F raise `cond_bad`. For these codes `res_mask` is zero and `flag_invalid` is 0.
- R5: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. A lane with a NaN in either operand is unordered. Every lane has exactly one of the four outcomes.
- R6: +0 and -0 compare equal. Ordered compares respect sign: a negative value is less than a positive value, and between two negatives the larger magnitude is less.
- R7: A signaling NaN has the fraction MSB clear (bit 22 for single, bit 51 for double). The quiet compare raises `flag_invalid` only when a lane holds a signaling NaN. The signaling compare raises it when a lane holds any NaN.
- R8: `flag_invalid` is the OR over the lanes of the selected precision only. In double mode, NaN patterns that exist only in the 32-bit view have no effect.
- R9: Outputs are registered with one cycle of latency. They load on a rising edge where `op_en`=1 and hold while `op_en`=0. Reset makes all outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Load the result registers this cycle |
| dbl_sel | input | 1 | 0: four single lanes, 1: two double lanes |
| cond | input | 5 | Condition code: bit 0 selects signaling, bits [4:1] select the relation |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| res_mask | output | 128 | Per-lane all-ones or all-zeros result |
| cond_bad | output | 1 | Condition code is illegal |
| flag_invalid | output | 1 | Invalid-operation flag for the operation |

## Verification
The bench drives signed zeros of mixed sign, negative pairs, infinities, quiet and signaling NaNs, and lanes copied from one operand to the other. A unit that compared raw bit patterns would order -0 below +0 and would reverse the order of negative numbers. A unit that mixed up the NaN quiet bit would flag invalid for quiet NaNs under a quiet compare. The bench sweeps every one of the 32 condition codes, so a wrong table entry shows up as a wrong mask, and a missing illegal decode shows up as a nonzero result. A double-mode case places a signaling-NaN pattern in the 32-bit view of a finite double, which catches a flag that ORs single-lane terms in double mode.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // outcome bit positions in a 4-bit relation vector
  localparam int unsigned REL_LT = 0;
  localparam int unsigned REL_EQ = 1;
  localparam int unsigned REL_GT = 2;
  localparam int unsigned REL_UN = 3;

  localparam logic [3:0] M_LT = 4'b0001;
  localparam logic [3:0] M_EQ = 4'b0010;
  localparam logic [3:0] M_GT = 4'b0100;
  localparam logic [3:0] M_UN = 4'b1000;

  typedef struct packed {
    logic       bad;
    logic       sig;
    logic [3:0] mask;
  } cond_t;
endpackage

// File: rtl/fcmp_cond_dec.sv
module fcmp_cond_dec
  import fcmp_pkg::*;
(
  input  logic [4:0] code,
  output cond_t      dec
);
  always_comb begin
    dec.sig = code[0];
    dec.bad = 1'b0;
    case (code[4:1])
      4'd0:    dec.mask = 4'b0000;
      4'd1:    dec.mask = M_LT;
      4'd2:    dec.mask = M_EQ;
      4'd3:    dec.mask = M_LT | M_EQ;
      4'd4:    dec.mask = M_UN;
      4'd5:    dec.mask = M_UN | M_LT;
      4'd6:    dec.mask = M_UN | M_EQ;
      4'd7:    dec.mask = M_UN | M_LT | M_EQ;
      4'd8:    dec.mask = M_LT | M_GT;
      4'd10:   dec.mask = M_LT | M_EQ | M_GT;
      4'd12:   dec.mask = M_UN | M_LT | M_GT;
      default: begin
        dec.mask = 4'b0000;
        dec.bad  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned EW = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [3:0]   rel,
  output logic         any_nan,
  output logic         sig_nan
);
  localparam int unsigned FW = W - EW - 1;

  logic [EW-1:0] exp_a, exp_b;
  logic [FW-1:0] frc_a, frc_b;
  logic [W-2:0]  mag_a, mag_b;
  logic          sgn_a, sgn_b, nan_a, nan_b, snan_a, snan_b;
  logic          mag_gt;

  assign sgn_a  = opa[W-1];
  assign sgn_b  = opb[W-1];
  assign mag_a  = opa[W-2:0];
  assign mag_b  = opb[W-2:0];
  assign exp_a  = opa[W-2 -: EW];
  assign exp_b  = opb[W-2 -: EW];
  assign frc_a  = opa[FW-1:0];
  assign frc_b  = opb[FW-1:0];
  assign nan_a  = (&exp_a) && (|frc_a);
  assign nan_b  = (&exp_b) && (|frc_b);
  assign snan_a = nan_a && !frc_a[FW-1];
  assign snan_b = nan_b && !frc_b[FW-1];
  assign mag_gt = mag_a > mag_b;

  assign any_nan = nan_a || nan_b;
  assign sig_nan = snan_a || snan_b;

  always_comb begin
    rel = 4'b0000;
    if (any_nan) begin
      rel[REL_UN] = 1'b1;
    end else if ((mag_a == '0) && (mag_b == '0)) begin
      rel[REL_EQ] = 1'b1;
    end else if (sgn_a != sgn_b) begin
      if (sgn_a) rel[REL_LT] = 1'b1;
      else       rel[REL_GT] = 1'b1;
    end else if (mag_a == mag_b) begin
      rel[REL_EQ] = 1'b1;
    end else if (mag_gt ^ sgn_a) begin
      rel[REL_GT] = 1'b1;
    end else begin
      rel[REL_LT] = 1'b1;
    end
  end
endmodule

// File: rtl/vfcmp_unit.sv
module vfcmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned SW   = 32,
  parameter int unsigned SEW  = 8,
  parameter int unsigned DW   = 64,
  parameter int unsigned DEW  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_en,
  input  logic            dbl_sel,
  input  logic [4:0]      cond,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic [VLEN-1:0] res_mask,
  output logic            cond_bad,
  output logic            flag_invalid
);
  localparam int unsigned NS = VLEN / SW;
  localparam int unsigned ND = VLEN / DW;

  cond_t dec;

  fcmp_cond_dec u_dec (
    .code (cond),
    .dec  (dec)
  );

  logic [NS-1:0][3:0] s_rel;
  logic [NS-1:0]      s_nan, s_snan, s_hit, s_inv;
  logic [ND-1:0][3:0] d_rel;
  logic [ND-1:0]      d_nan, d_snan, d_hit, d_inv;
  logic [VLEN-1:0]    s_vec, d_vec;

  for (genvar gi = 0; gi < NS; gi++) begin : g_sgl
    fcmp_lane #(.W(SW), .EW(SEW)) u_lane (
      .opa     (src_a[gi*SW +: SW]),
      .opb     (src_b[gi*SW +: SW]),
      .rel     (s_rel[gi]),
      .any_nan (s_nan[gi]),
      .sig_nan (s_snan[gi])
    );
    assign s_hit[gi]             = |(s_rel[gi] & dec.mask);
    assign s_inv[gi]             = dec.sig ? s_nan[gi] : s_snan[gi];
    assign s_vec[gi*SW +: SW]    = {SW{s_hit[gi]}};

    AST_ONE_OUTCOME_S: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |-> $onehot(s_rel[gi])); // R5
    AST_NAN_UNORDERED_S: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && s_nan[gi]) |-> s_rel[gi][REL_UN]); // R5
  end

  for (genvar gd = 0; gd < ND; gd++) begin : g_dbl
    fcmp_lane #(.W(DW), .EW(DEW)) u_lane (
      .opa     (src_a[gd*DW +: DW]),
      .opb     (src_b[gd*DW +: DW]),
      .rel     (d_rel[gd]),
      .any_nan (d_nan[gd]),
      .sig_nan (d_snan[gd])
    );
    assign d_hit[gd]             = |(d_rel[gd] & dec.mask);
    assign d_inv[gd]             = dec.sig ? d_nan[gd] : d_snan[gd];
    assign d_vec[gd*DW +: DW]    = {DW{d_hit[gd]}};

    AST_ONE_OUTCOME_D: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && dbl_sel) |-> $onehot(d_rel[gd])); // R5
    AST_DBL_LANE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && dbl_sel) |=> ((res_mask[gd*DW +: DW] == '0) ||
                              (res_mask[gd*DW +: DW] == '1))); // R1
  end

  logic [VLEN-1:0] res_nxt;
  logic            bad_nxt, inv_nxt;

  always_comb begin
    res_nxt = dbl_sel ? d_vec : s_vec;
    inv_nxt = dbl_sel ? (|d_inv) : (|s_inv);
    bad_nxt = dec.bad;
    if (dec.bad) begin
      res_nxt = '0;
      inv_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_mask     <= '0;
      cond_bad     <= 1'b0;
      flag_invalid <= 1'b0;
    end else if (op_en) begin
      res_mask     <= res_nxt;
      cond_bad     <= bad_nxt;
      flag_invalid <= inv_nxt;
    end
  end

  for (genvar gk = 0; gk < NS; gk++) begin : g_chk
    AST_LANE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_mask[gk*SW +: SW] == '0) || (res_mask[gk*SW +: SW] == '1)); // R1
  end

  AST_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cond_bad |-> ((res_mask == '0) && !flag_invalid)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(res_mask) && $stable(cond_bad) && $stable(flag_invalid))); // R9
  AST_QUIET_NO_QNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !cond[0] && !dbl_sel && (s_snan == '0)) |=> !flag_invalid); // R7
endmodule

// File: tb/test_vfcmp_unit.sv
module test_vfcmp_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_en;
  logic         dbl_sel;
  logic [4:0]   cond;
  logic [127:0] src_a, src_b;
  logic [127:0] res_mask;
  logic         cond_bad, flag_invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vfcmp_unit i_vfcmp_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_en        (op_en),
    .dbl_sel      (dbl_sel),
    .cond         (cond),
    .src_a        (src_a),
    .src_b        (src_b),
    .res_mask     (res_mask),
    .cond_bad     (cond_bad),
    .flag_invalid (flag_invalid)
  );

  // expected model: returns {bad, inv, mask}
  function automatic logic [129:0] model(logic [127:0] a, logic [127:0] b,
                                         logic dbl, logic [4:0] c);
    logic [127:0] m;
    logic         bad, inv;
    logic [3:0]   set; // {un, gt, eq, lt}
    int           n;
    m = '0; inv = 1'b0;
    bad = (c == 5'h12) || (c == 5'h13) || (c == 5'h16) || (c == 5'h17) || (c > 5'h19);
    case (c)
      5'h00, 5'h01: set = 4'b0000;
      5'h02, 5'h03: set = 4'b0001;
      5'h04, 5'h05: set = 4'b0010;
      5'h06, 5'h07: set = 4'b0011;
      5'h08, 5'h09: set = 4'b1000;
      5'h0A, 5'h0B: set = 4'b1001;
      5'h0C, 5'h0D: set = 4'b1010;
      5'h0E, 5'h0F: set = 4'b1011;
      5'h10, 5'h11: set = 4'b0101;
      5'h14, 5'h15: set = 4'b0111;
      5'h18, 5'h19: set = 4'b1101;
      default:      set = 4'b0000;
    endcase
    n = dbl ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      logic [63:0] x, y;
      logic        xn, yn, xs, ys, hit;
      logic signed [64:0] kx, ky;
      if (dbl) begin
        x  = a[i*64 +: 64]; y = b[i*64 +: 64];
        xn = (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        yn = (y[62:52] == 11'h7FF) && (y[51:0] != 0);
        xs = xn && !x[51]; ys = yn && !y[51];
        kx = x[63] ? -$signed({2'b0, x[62:0]}) : $signed({2'b0, x[62:0]});
        ky = y[63] ? -$signed({2'b0, y[62:0]}) : $signed({2'b0, y[62:0]});
      end else begin
        x  = {32'b0, a[i*32 +: 32]}; y = {32'b0, b[i*32 +: 32]};
        xn = (x[30:23] == 8'hFF) && (x[22:0] != 0);
        yn = (y[30:23] == 8'hFF) && (y[22:0] != 0);
        xs = xn && !x[22]; ys = yn && !y[22];
        kx = x[31] ? -$signed({34'b0, x[30:0]}) : $signed({34'b0, x[30:0]});
        ky = y[31] ? -$signed({34'b0, y[30:0]}) : $signed({34'b0, y[30:0]});
      end
      if (xn || yn)     hit = set[3];
      else if (kx < ky) hit = set[0];
      else if (kx > ky) hit = set[2];
      else              hit = set[1];
      if (c[0] ? (xn || yn) : (xs || ys)) inv = 1'b1;
      if (hit) begin
        if (dbl) m[i*64 +: 64] = '1;
        else     m[i*32 +: 32] = '1;
      end
    end
    if (bad) begin
      m = '0; inv = 1'b0;
    end
    return {bad, inv, m};
  endfunction

  function automatic logic [31:0] gen32();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7FC0_0000 | ($urandom & 32'h003F_FFFF);
      3: return 32'h7F80_0001 | ($urandom & 32'h001F_FFFF);
      4: return {$urandom_range(1, 0) == 1, 31'h7F80_0000};
      5: return {$urandom_range(1, 0) == 1, 8'h7F, 23'($urandom % 4)};
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [63:0] gen64();
    case ($urandom % 8)
      0: return 64'h0;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF8_0000_0000_0000 | {32'h0, $urandom};
      3: return 64'h7FF0_0000_0000_0001 | {32'h0, $urandom};
      4: return {$urandom_range(1, 0) == 1, 63'h7FF0_0000_0000_0000};
      5: return {$urandom_range(1, 0) == 1, 11'h3FF, 52'($urandom % 4)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mask: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [127:0] a, logic [127:0] b,
                        logic dbl, logic [4:0] c);
    logic [129:0] e;
    e = model(a, b, dbl, c);
    @(negedge clk);
    src_a = a; src_b = b; dbl_sel = dbl; cond = c; op_en = 1'b1;
    @(negedge clk);
    op_en = 1'b0;
    check_vec(req, res_mask, e[127:0]);
    check_bit(req, "invalid", flag_invalid, e[128]);
    check_bit(req, "cond_bad", cond_bad, e[129]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] a, b, hold_m;
    void'($urandom(32'd1234));
    rst_n = 1'b0; op_en = 1'b0; dbl_sel = 1'b0; cond = 5'h0;
    src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check_vec("R9", res_mask, '0);
    check_bit("R9", "invalid", flag_invalid, 1'b0);
    check_bit("R9", "cond_bad", cond_bad, 1'b0);
    rst_n = 1'b1;

    // R6 signed zeros and sign-aware ordering (1.0=3F800000, -1.0=BF800000, -2.0=C0000000)
    run_op("R6", {32'h8000_0000, 32'h0, 32'hBF80_0000, 32'hC000_0000},
                 {32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000}, 1'b0, 5'h04);
    run_op("R6", {32'h8000_0000, 32'h0, 32'hBF80_0000, 32'hC000_0000},
                 {32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000}, 1'b0, 5'h02);
    // R5 NaN in one operand only gives unordered
    run_op("R5", {32'h7FC0_0000, 32'h0, 32'h7F80_0000, 32'h1}, {32'h1, 32'hFF80_0001, 32'h7F80_0000, 32'h1},
           1'b0, 5'h08);
    // R7 / R2 quiet NaN under quiet and signaling compare
    run_op("R7", {96'h0, 32'h7FC0_0000}, '0, 1'b0, 5'h04);
    run_op("R2", {96'h0, 32'h7FC0_0000}, '0, 1'b0, 5'h05);
    // R7 signaling NaN under quiet compare
    run_op("R7", {96'h0, 32'h7F80_0001}, '0, 1'b0, 5'h04);
    run_op("R7", {64'h0, 64'h7FF0_0000_0000_0001}, '0, 1'b1, 5'h00);
    // R8 single-view sNaN inside a finite double
    run_op("R8", {64'h0, 32'h7FA0_0000, 32'h0}, '0, 1'b1, 5'h04);
    run_op("R8", {64'h0, 32'h7FA0_0000, 32'h0}, '0, 1'b0, 5'h04);
    // R1 double lane ordering
    run_op("R1", {64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000},
                 {64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000}, 1'b1, 5'h02);
    // R3 / R4 sweep all codes with mixed lanes
    a = {32'h7FC0_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000};
    b = {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000};
    for (int c = 0; c < 32; c++) begin
      if ((c == 'h12) || (c == 'h13) || (c == 'h16) || (c == 'h17) || (c > 'h19))
        run_op("R4", a, b, 1'b0, 5'(c));
      else
        run_op("R3", a, b, 1'b0, 5'(c));
    end
    // R9 hold while op_en low
    hold_m = res_mask;
    @(negedge clk);
    src_a = ~src_a; cond = 5'h10; dbl_sel = 1'b1;
    @(negedge clk);
    check_vec("R9", res_mask, hold_m);
    // random mix
    for (int it = 0; it < 600; it++) begin
      logic d;
      d = $urandom_range(1, 0) == 1;
      for (int l = 0; l < 4; l++) begin
        if (d && l < 2) begin
          a[l*64 +: 64] = gen64();
          b[l*64 +: 64] = ($urandom % 4 == 0) ? a[l*64 +: 64] : gen64();
        end else if (!d) begin
          a[l*32 +: 32] = gen32();
          b[l*32 +: 32] = ($urandom % 4 == 0) ? a[l*32 +: 32] : gen32();
        end
      end
      run_op("R3", a, b, d, 5'($urandom % 26));
    end
    finish_run();
  end
endmodule